// File: doc/BRIEF.md
# Converter Control Serial Write Engine

This block is a write-only serial master that programs converter chips over a three-wire link. The link has a shared clock line, a shared data line, and one active-low select for each chip. A host asks for one of three operations. A direct write sends one byte to one register of one chip. A masked update changes selected bits of a register on every chip in turn. A sample-rate hint is turned into a masked update of the converters' clock-format register.

Every transfer is a 16-bit command frame that goes out most significant bit first. Data changes while the clock is low, and the receiver samples it on the rising clock edge. The length of each clock phase is set in system clock cycles by the host. The block keeps a shadow copy of every register of every chip, built from the bytes it has sent. Masked updates merge their bits into that copy, so nothing needs to be read back from the converters.

Top module: `cnv_serial_writer`

## Requirements
- R1: Each frame carries bits 15:14 = 2'b10 (device address 2), bit 13 = 1 (write flag), bits 12:8 = register address, and bits 7:0 = data byte.
- R2: A frame is exactly 16 bits, sent from bit 15 down to bit 0, with one rising edge of serClk per bit.
- R3: Each bit has a low phase and then a high phase. Each phase lasts phaseCycles system clocks, and a value of 0 counts as 1. serData changes only when serClk falls, and it holds steady while serClk is high during a frame.
- R4: During a frame only the addressed chip's select is low. It drops one setup phase before the first falling clock edge and rises after the high phase of bit 0.
- R5: A direct write with a chip index of NUM_CHIPS or more drives no select and sends no frame. Busy stays low, and reject pulses high for one cycle on the clock after the request.
- R6: When idle, serClk and serData are high, every select is high, and busy is low. This also holds after reset.
- R7: done pulses high for exactly one cycle, in the cycle where busy falls.
- R8: A masked update sends one frame per chip, in ascending chip order. Each byte is (shadow & ~mask) | (value & mask). The shadow of each register of each chip holds the last byte sent to it and resets to 0.
- R9: A rate hint above 108000 performs a masked update of register 2 with mask 0x0F and value 0x0A. A hint from 54001 to 108000 uses value 0x05. A hint from 1 to 54000 uses value 0x00. A hint of 0 causes no activity.
- R10: Start requests that arrive while busy are ignored. If requests arrive together, the direct write wins over the masked update, and the masked update wins over the rate hint.
- R11: busy goes high on the clock after an accepted request. It stays high until the last frame of that request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseCycles | input | PHASE_W | Length of each serial clock phase in system clocks (0 means 1) |
| wrStart | input | 1 | Request a direct write |
| wrChip | input | CHIP_IDX_W | Target chip of a direct write |
| wrAddr | input | 5 | Register address of a direct write |
| wrData | input | 8 | Data byte of a direct write |
| rmwStart | input | 1 | Request a masked update of all chips |
| rmwAddr | input | 5 | Register address of a masked update |
| rmwMask | input | 8 | Bits to change in a masked update |
| rmwValue | input | 8 | New values for the masked bits |
| rateStart | input | 1 | Request a rate-hint update |
| rateHz | input | RATE_W | Sample-rate hint in Hz |
| serClk | output | 1 | Serial clock, idles high |
| serData | output | 1 | Serial data, idles high |
| serSelN | output | NUM_CHIPS | Active-low chip selects |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| reject | output | 1 | One-cycle pulse when a direct write names a chip that does not exist |

## Verification
Two situations are hard to reach from the ports. The first is a second request that lands in the middle of a frame. The bench pulses all three start inputs several cycles after a write has begun, then confirms that exactly one frame appears and that the shadow model is unchanged. The second is a masked update whose bytes depend on history that differs between the two chips. To create that history, the bench interleaves direct writes to single chips with masked updates and rate hints, and it varies the phase length between operations. It then compares every captured frame against a model of the shadow registers kept in the bench.

// File: rtl/cnv_ser_pkg.sv
package cnv_ser_pkg;

  typedef enum logic [1:0] {
    REQ_WRITE  = 2'd0,
    REQ_MASKED = 2'd1,
    REQ_RATE   = 2'd2
  } reqKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    reqKind_t kind;
    logic     loadFrame;
    logic     clkLow;
    logic     clkHigh;
    logic     frameEnd;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SETUP = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4
  } ctrlState_t;

endpackage

// File: rtl/cnv_ser_ctrl.sv
module cnv_ser_ctrl
  import cnv_ser_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CHIP_IDX_W = 2,
  parameter int PHASE_W    = 8,
  parameter int RATE_W     = 18,
  parameter int FRAME_W    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PHASE_W-1:0]    phaseCycles,
  input  logic                  wrStart,
  input  logic [CHIP_IDX_W-1:0] wrChip,
  input  logic                  rmwStart,
  input  logic                  rateStart,
  input  logic [RATE_W-1:0]     rateHz,
  output dpStrobe_t             strobe,
  output logic [CHIP_IDX_W-1:0] curChip,
  output logic                  busy,
  output logic                  done,
  output logic                  reject
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0]      LAST_BIT  = BIT_W'(FRAME_W - 1);
  localparam logic [CHIP_IDX_W-1:0] LAST_CHIP = CHIP_IDX_W'(NUM_CHIPS - 1);

  ctrlState_t         state;
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] phaseLoad;
  logic [BIT_W-1:0]   bitIdx;
  logic               maskedRun;
  logic               phaseEnd;
  logic               wrOk;
  logic               rateGo;

  assign phaseLoad = (phaseCycles == '0) ? '0 : phaseCycles - PHASE_W'(1);
  assign phaseEnd  = (phaseCnt == '0);
  assign wrOk      = (int'(wrChip) < NUM_CHIPS);
  assign rateGo    = rateStart && (rateHz != '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.kind = REQ_WRITE;
    unique case (state)
      ST_IDLE: begin
        if (wrStart) begin
          strobe.capture = wrOk;
          strobe.kind    = REQ_WRITE;
        end else if (rmwStart) begin
          strobe.capture = 1'b1;
          strobe.kind    = REQ_MASKED;
        end else if (rateGo) begin
          strobe.capture = 1'b1;
          strobe.kind    = REQ_RATE;
        end
      end
      ST_LOAD:  strobe.loadFrame = 1'b1;
      ST_SETUP: strobe.clkLow = phaseEnd;
      ST_LOW:   strobe.clkHigh = phaseEnd;
      ST_HIGH: begin
        if (phaseEnd) begin
          if (bitIdx == '0) strobe.frameEnd = 1'b1;
          else              strobe.clkLow   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      bitIdx    <= '0;
      curChip   <= '0;
      maskedRun <= 1'b0;
      done      <= 1'b0;
      reject    <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wrStart) begin
            if (wrOk) begin
              state     <= ST_LOAD;
              curChip   <= wrChip;
              maskedRun <= 1'b0;
            end else begin
              reject <= 1'b1;
            end
          end else if (rmwStart || rateGo) begin
            state     <= ST_LOAD;
            curChip   <= '0;
            maskedRun <= 1'b1;
          end
        end
        ST_LOAD: begin
          state    <= ST_SETUP;
          phaseCnt <= phaseLoad;
        end
        ST_SETUP: begin
          if (phaseEnd) begin
            state    <= ST_LOW;
            phaseCnt <= phaseLoad;
            bitIdx   <= LAST_BIT;
          end else begin
            phaseCnt <= phaseCnt - PHASE_W'(1);
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= phaseLoad;
          end else begin
            phaseCnt <= phaseCnt - PHASE_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            if (bitIdx == '0) begin
              if (maskedRun && (curChip != LAST_CHIP)) begin
                curChip <= curChip + CHIP_IDX_W'(1);
                state   <= ST_LOAD;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              bitIdx   <= bitIdx - BIT_W'(1);
              state    <= ST_LOW;
              phaseCnt <= phaseLoad;
            end
          end else begin
            phaseCnt <= phaseCnt - PHASE_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cnv_ser_datapath.sv
module cnv_ser_datapath
  import cnv_ser_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CHIP_IDX_W = 2,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int RATE_W     = 18,
  parameter int DEV_ADDR   = 2,
  parameter int RATE_REG   = 2,
  parameter int RATE_HI    = 108000,
  parameter int RATE_MID   = 54000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [CHIP_IDX_W-1:0] curChip,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rmwAddr,
  input  logic [DATA_W-1:0]     rmwMask,
  input  logic [DATA_W-1:0]     rmwValue,
  input  logic [RATE_W-1:0]     rateHz,
  output logic                  serClk,
  output logic                  serData,
  output logic [NUM_CHIPS-1:0]  serSelN
);

  localparam int FRAME_W = 2 + 1 + ADDR_W + DATA_W;
  localparam int REGS    = 2 ** ADDR_W;
  localparam int SEL_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
  localparam logic [1:0]        DEV_BITS   = 2'(DEV_ADDR);
  localparam logic [DATA_W-1:0] RATE_FIELD = DATA_W'(8'h0F);
  localparam logic [DATA_W-1:0] CODE_HI    = DATA_W'(8'h0A);
  localparam logic [DATA_W-1:0] CODE_MID   = DATA_W'(8'h05);

  logic [ADDR_W-1:0]  opAddr;
  logic [DATA_W-1:0]  opMask;
  logic [DATA_W-1:0]  opValue;
  logic [DATA_W-1:0]  frameByte;
  logic [DATA_W-1:0]  nextByte;
  logic [DATA_W-1:0]  rateCode;
  logic [FRAME_W-1:0] shiftQ;
  logic [NUM_CHIPS-1:0] selNext;
  logic [SEL_W-1:0]   chipSel;
  logic [DATA_W-1:0]  shadowMem [NUM_CHIPS][REGS];

  assign chipSel = SEL_W'(curChip);

  always_comb begin
    if (rateHz > RATE_W'(RATE_HI))       rateCode = CODE_HI;
    else if (rateHz > RATE_W'(RATE_MID)) rateCode = CODE_MID;
    else                                 rateCode = '0;
  end

  // a direct write is a masked update with every bit selected
  assign nextByte = (shadowMem[chipSel][opAddr] & ~opMask) | (opValue & opMask);

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_sel
    assign selNext[i] = (curChip != CHIP_IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr    <= '0;
      opMask    <= '0;
      opValue   <= '0;
      frameByte <= '0;
      shiftQ    <= '0;
      serClk    <= 1'b1;
      serData   <= 1'b1;
      serSelN   <= '1;
      for (int c = 0; c < NUM_CHIPS; c++)
        for (int r = 0; r < REGS; r++)
          shadowMem[c][r] <= '0;
    end else begin
      if (strobe.capture) begin
        unique case (strobe.kind)
          REQ_MASKED: begin
            opAddr  <= rmwAddr;
            opMask  <= rmwMask;
            opValue <= rmwValue;
          end
          REQ_RATE: begin
            opAddr  <= ADDR_W'(RATE_REG);
            opMask  <= RATE_FIELD;
            opValue <= rateCode;
          end
          default: begin
            opAddr  <= wrAddr;
            opMask  <= '1;
            opValue <= wrData;
          end
        endcase
      end
      if (strobe.loadFrame) begin
        shiftQ    <= {DEV_BITS, 1'b1, opAddr, nextByte};
        frameByte <= nextByte;
        serSelN   <= selNext;
      end
      if (strobe.clkLow) begin
        serClk  <= 1'b0;
        serData <= shiftQ[FRAME_W-1];
        shiftQ  <= {shiftQ[FRAME_W-2:0], 1'b0};
      end
      if (strobe.clkHigh) serClk <= 1'b1;
      if (strobe.frameEnd) begin
        serClk  <= 1'b1;
        serData <= 1'b1;
        serSelN <= '1;
        shadowMem[chipSel][opAddr] <= frameByte;
      end
    end
  end

endmodule

// File: rtl/cnv_serial_writer.sv
module cnv_serial_writer
  import cnv_ser_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CHIP_IDX_W = 2,
  parameter int PHASE_W    = 8,
  parameter int RATE_W     = 18,
  parameter int DEV_ADDR   = 2,
  parameter int RATE_REG   = 2,
  parameter int RATE_HI    = 108000,
  parameter int RATE_MID   = 54000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PHASE_W-1:0]    phaseCycles,
  input  logic                  wrStart,
  input  logic [CHIP_IDX_W-1:0] wrChip,
  input  logic [4:0]            wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  rmwStart,
  input  logic [4:0]            rmwAddr,
  input  logic [7:0]            rmwMask,
  input  logic [7:0]            rmwValue,
  input  logic                  rateStart,
  input  logic [RATE_W-1:0]     rateHz,
  output logic                  serClk,
  output logic                  serData,
  output logic [NUM_CHIPS-1:0]  serSelN,
  output logic                  busy,
  output logic                  done,
  output logic                  reject
);

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 2 + 1 + ADDR_W + DATA_W;

  dpStrobe_t             strobe;
  logic [CHIP_IDX_W-1:0] curChip;

  cnv_ser_ctrl #(
    .NUM_CHIPS(NUM_CHIPS), .CHIP_IDX_W(CHIP_IDX_W), .PHASE_W(PHASE_W),
    .RATE_W(RATE_W), .FRAME_W(FRAME_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .phaseCycles(phaseCycles),
    .wrStart(wrStart), .wrChip(wrChip), .rmwStart(rmwStart),
    .rateStart(rateStart), .rateHz(rateHz),
    .strobe(strobe), .curChip(curChip),
    .busy(busy), .done(done), .reject(reject)
  );

  cnv_ser_datapath #(
    .NUM_CHIPS(NUM_CHIPS), .CHIP_IDX_W(CHIP_IDX_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .RATE_W(RATE_W), .DEV_ADDR(DEV_ADDR),
    .RATE_REG(RATE_REG), .RATE_HI(RATE_HI), .RATE_MID(RATE_MID)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curChip(curChip),
    .wrAddr(wrAddr), .wrData(wrData), .rmwAddr(rmwAddr),
    .rmwMask(rmwMask), .rmwValue(rmwValue), .rateHz(rateHz),
    .serClk(serClk), .serData(serData), .serSelN(serSelN)
  );

endmodule

// File: rtl/cnv_serial_writer_chk.sv
module cnv_serial_writer_chk #(
  parameter int NUM_CHIPS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 serClk,
  input logic                 serData,
  input logic [NUM_CHIPS-1:0] serSelN,
  input logic                 busy,
  input logic                 done,
  input logic                 reject
);

  logic       clkPrev;
  logic [5:0] frameBits;

  // counts rising serial clock edges while a select is low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev   <= 1'b1;
      frameBits <= '0;
    end else begin
      clkPrev <= serClk;
      if (&serSelN)                 frameBits <= '0;
      else if (serClk && !clkPrev)  frameBits <= frameBits + 6'd1;
    end
  end

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~serSelN));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(serData) && !(&serSelN)) |-> !serClk);

  p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serClk && serData && (&serSelN)));

  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> (!busy && (&serSelN)));

  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_frame_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&serSelN) |-> (frameBits == 6'd16));

endmodule

bind cnv_serial_writer cnv_serial_writer_chk #(.NUM_CHIPS(NUM_CHIPS)) chkInst (
  .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
  .serSelN(serSelN), .busy(busy), .done(done), .reject(reject)
);

// File: tb/cnv_serial_writer_test.sv
module cnv_serial_writer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  phaseCycles = 8'd1;
  logic        wrStart = 1'b0;
  logic [1:0]  wrChip = '0;
  logic [4:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rmwStart = 1'b0;
  logic [4:0]  rmwAddr = '0;
  logic [7:0]  rmwMask = '0;
  logic [7:0]  rmwValue = '0;
  logic        rateStart = 1'b0;
  logic [17:0] rateHz = '0;
  logic        serClk, serData, busy, done, reject;
  logic [1:0]  serSelN;

  always #10 clk = ~clk;

  cnv_serial_writer uut (
    .clk(clk), .rstN(rstN), .phaseCycles(phaseCycles),
    .wrStart(wrStart), .wrChip(wrChip), .wrAddr(wrAddr), .wrData(wrData),
    .rmwStart(rmwStart), .rmwAddr(rmwAddr), .rmwMask(rmwMask), .rmwValue(rmwValue),
    .rateStart(rateStart), .rateHz(rateHz),
    .serClk(serClk), .serData(serData), .serSelN(serSelN),
    .busy(busy), .done(done), .reject(reject)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0]  shModel [2][32];
  logic [15:0] frWord [512];
  int          frChip [512];
  int          frCount = 0;
  logic [15:0] expWord [4];
  int          expChip [4];
  int          expN = 0;
  int          startIdx = 0;

  // monitor state
  bit          prevAll = 1'b1, prevClk = 1'b1, prevData = 1'b1;
  logic [15:0] curWord;
  int          curChip = 0;
  int          lowRun = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input logic [4:0] a, input logic [7:0] d);
    return {2'b10, 1'b1, a, d};
  endfunction

  function automatic logic [7:0] rateCode(input int hz);
    if (hz > 108000) return 8'h0A;
    if (hz > 54000)  return 8'h05;
    return 8'h00;
  endfunction

  function automatic int phaseEff();
    return (phaseCycles == 0) ? 1 : int'(phaseCycles);
  endfunction

  // serial monitor: captures frames, checks phase length and data hold (R3)
  always @(negedge clk) begin
    if (rstN) begin
      if (!(&serSelN)) begin
        if (prevAll) begin
          curWord = '0;
          lowRun  = 0;
          curChip = serSelN[0] ? 1 : 0;
        end
        if (!serClk) lowRun++;
        if (serClk && !prevClk) begin
          check(lowRun == phaseEff(), "R3 low phase length", lowRun, phaseEff());
          curWord = {curWord[14:0], serData};
          lowRun  = 0;
        end
        if (serClk && prevClk && !prevAll && (serData != prevData))
          check(1'b0, "R3 data moved while clock high", serData, prevData);
      end else if (!prevAll && frCount < 512) begin
        frWord[frCount] = curWord;
        frChip[frCount] = curChip;
        frCount++;
      end
      prevAll  = &serSelN;
      prevClk  = serClk;
      prevData = serData;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expectWrite(input int chip, input logic [4:0] a, input logic [7:0] d);
    expChip[expN] = chip;
    expWord[expN] = mkWord(a, d);
    expN++;
    shModel[chip][a] = d;
  endtask

  task automatic expectMasked(input logic [4:0] a, input logic [7:0] m, input logic [7:0] v);
    for (int c = 0; c < 2; c++) begin
      logic [7:0] b;
      b = (shModel[c][a] & ~m) | (v & m);
      expectWrite(c, a, b);
    end
  endtask

  task automatic launch(input bit w, input bit m, input bit r, input int chip,
                        input int a, input int d, input int mk, input int v, input int hz);
    @(negedge clk);
    startIdx = frCount;
    wrStart = w; wrChip = 2'(chip); wrAddr = 5'(a); wrData = 8'(d);
    rmwStart = m; rmwAddr = 5'(a); rmwMask = 8'(mk); rmwValue = 8'(v);
    rateStart = r; rateHz = 18'(hz);
    @(negedge clk);
    wrStart = 0; rmwStart = 0; rateStart = 0;
  endtask

  task automatic finishOp(input string req);
    int n = 0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R7 done pulse", done, 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done lasts one cycle", done, 0);
    check(frCount - startIdx == expN, {req, " frame count"}, frCount - startIdx, expN);
    if (frCount - startIdx == expN) begin
      for (int i = 0; i < expN; i++) begin
        check(frChip[startIdx+i] == expChip[i], {req, " R4 chip"}, frChip[startIdx+i], expChip[i]);
        check(frWord[startIdx+i] == expWord[i], {req, " R1 word"}, frWord[startIdx+i], expWord[i]);
      end
    end
    expN = 0;
  endtask

  task automatic noActivity(input string req);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy || !(&serSelN)) check(1'b0, req, {busy, serSelN}, 3'b011);
    end
    check(frCount == startIdx, {req, " no frame"}, frCount - startIdx, 0);
  endtask

  initial begin
    int seedVal;
    int rates [8];
    seedVal = $urandom(32'd20240611);
    rates = '{0, 44100, 48000, 54000, 54001, 96000, 108000, 192000};
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 32; r++) shModel[c][r] = 8'h00;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6: idle after reset
    check({serClk, serData, serSelN, busy, done} == 6'b111100, "R6 reset state",
          {serClk, serData, serSelN, busy, done}, 6'b111100);

    // R1 R2 R3 R4: direct writes at two phase lengths
    phaseCycles = 8'd1;
    launch(1, 0, 0, 0, 3, 8'hA5, 0, 0, 0);
    expectWrite(0, 5'd3, 8'hA5);
    finishOp("R1 write chip0");
    phaseCycles = 8'd2;
    launch(1, 0, 0, 1, 31, 8'h00, 0, 0, 0);
    expectWrite(1, 5'd31, 8'h00);
    finishOp("R2 write chip1 reg31");
    phaseCycles = 8'd0;
    launch(1, 0, 0, 1, 0, 8'hFF, 0, 0, 0);
    expectWrite(1, 5'd0, 8'hFF);
    finishOp("R3 zero phase");
    check({serClk, serData, serSelN} == 4'b1111, "R6 idle lines", {serClk, serData, serSelN}, 4'hF);

    // R5: out-of-range chip indices
    phaseCycles = 8'd1;
    for (int ch = 2; ch < 4; ch++) begin
      launch(1, 0, 0, ch, 4, 8'h12, 0, 0, 0);
      check(reject == 1'b1, "R5 reject pulse", reject, 1);
      check(busy == 1'b0, "R5 busy stays low", busy, 0);
      noActivity("R5 rejected write");
    end

    // R8: masked update over differing shadows
    launch(0, 1, 0, 0, 3, 0, 8'hF0, 8'h3C, 0);
    expectMasked(5'd3, 8'hF0, 8'h3C);
    finishOp("R8 masked update");

    // R9: rate hints around thresholds
    launch(0, 0, 1, 0, 0, 0, 0, 0, 0);
    noActivity("R9 zero rate");
    for (int i = 1; i < 8; i++) begin
      launch(0, 0, 1, 0, 0, 0, 0, 0, rates[i]);
      expectMasked(5'd2, 8'h0F, rateCode(rates[i]));
      finishOp("R9 rate hint");
    end

    // R10: requests during busy are ignored
    launch(1, 0, 0, 1, 5, 8'h77, 0, 0, 0);
    expectWrite(1, 5'd5, 8'h77);
    repeat (5) @(negedge clk);
    wrStart = 1; wrChip = 0; wrAddr = 5'd5; wrData = 8'h11;
    rmwStart = 1; rmwAddr = 5'd5; rmwMask = 8'hFF; rmwValue = 8'h22;
    rateStart = 1; rateHz = 18'd96000;
    @(negedge clk);
    wrStart = 0; rmwStart = 0; rateStart = 0;
    finishOp("R10 start while busy");

    // R10: priority of simultaneous requests
    launch(1, 1, 1, 1, 9, 8'h5A, 8'hFF, 8'hC3, 48000);
    expectWrite(1, 5'd9, 8'h5A);
    finishOp("R10 write wins");
    launch(0, 1, 1, 0, 9, 0, 8'h0F, 8'h06, 192000);
    expectMasked(5'd9, 8'h0F, 8'h06);
    finishOp("R10 masked wins over rate");

    // random mix
    for (int k = 0; k < 50; k++) begin
      int op;
      int a;
      int d;
      int m;
      op = $urandom_range(0, 2);
      a  = $urandom_range(0, 7);
      d  = $urandom_range(0, 255);
      m  = $urandom_range(0, 255);
      phaseCycles = 8'($urandom_range(0, 3));
      if (op == 0) begin
        int ch;
        ch = $urandom_range(0, 1);
        launch(1, 0, 0, ch, a, d, 0, 0, 0);
        expectWrite(ch, 5'(a), 8'(d));
        finishOp("R1 random write");
      end else if (op == 1) begin
        launch(0, 1, 0, 0, a, 0, m, d, 0);
        expectMasked(5'(a), 8'(m), 8'(d));
        finishOp("R8 random masked");
      end else begin
        int hz;
        hz = rates[$urandom_range(1, 7)];
        launch(0, 0, 1, 0, 0, 0, 0, 0, hz);
        expectMasked(5'd2, 8'h0F, rateCode(hz));
        finishOp("R9 random rate");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule